// File: doc/BRIEF.md
# Random-Word FIFO Harvester with Stall Escalation

This block is a small bus master that periodically empties a hardware random-number source's output FIFO into a local buffer of four words. After reset it programs the source once: it masks the source interrupt, loads the warm-up count and sets the enable bit. A timer then starts a first gathering pass after a short delay. Each later pass starts a fixed, longer interval after the previous one has ended.

During a pass the controller polls the source's count register. It then reads as many data words as are both available and still needed. It keeps polling until the buffer holds four words. A poll that finds the FIFO empty counts as an underrun. When the empty polls within one pass reach a programmable limit, the controller restarts the source once by toggling its enable bit. If the limit is reached again in the same pass, the source is switched off for good and the pass ends early.

At the end of every pass a one-cycle done strobe presents the number of words gathered, with the buffer contents beside it. A persistent underrun counter and a sticky stall flag are also visible.

Top module: `rng_harvest_ctrl`

## Requirements
- R1: After reset, and before any pass, the controller performs exactly three bus writes in this order: value 1 to the mask register (bit 0 set disables the source interrupt), the warm-up value to the count register, and value 1 to the control register (bit 0 is the enable bit).
- R2: The first count poll of the first pass puts `bus_req_o` high FIRST_DELAY+2 clock cycles after reset is released. Every later pass puts its first count poll on the bus INTERVAL+3 cycles after the cycle in which `done_o` was high.
- R3: Each poll is a read of the count register. The available-word number is taken only from bits [CNT_LSB+CNT_W-1:CNT_LSB] of the returned word (bits 31:24 by default), and all other bits are ignored.
- R4: After a non-empty poll the controller reads min(available, words still needed) words from the data register, one access each. The words are stored in buffer slots in arrival order, from slot 0 up to slot 3 (slot i at `words_o` bits [32i+31:32i]). Every pass asks for exactly four words.
- R5: Every poll that returns zero increments `underrun_o` by one. This counter is not cleared between passes. The same poll also increments a per-pass empty count, which starts at zero for each pass and is not cleared by later successful reads.
- R6: When the per-pass empty count first reaches the stall limit, the controller writes 0 to the control register, then 1 to the mask register, the warm-up value to the count register and 1 to the control register. It then clears the per-pass empty count and continues the pass with further polls.
- R7: When the limit is reached a second time in the same pass, the controller writes 0 to the control register and sets `stalled_o`. It ends the pass with the words gathered so far. `stalled_o` stays high, and no further bus access or pass takes place until reset.
- R8: The stall limit resets to 10 and is loaded from `lim_wd_i` in a cycle where `lim_we_i` is high. A limit of 0 behaves as a limit of 1.
- R9: `done_o` is high for exactly one cycle at the end of each pass. In that cycle `done_cnt_o` holds the number of words gathered (0 to 4), and the first `done_cnt_o` slots of `words_o` hold them.
- R10: A bus access holds `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` steady until a cycle with `bus_ack_i` high. `bus_rdata_i` is taken in that cycle. `bus_req_o` is low in the following cycle, and only one access is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lim_we_i | input | 1 | Load strobe for the stall limit |
| lim_wd_i | input | LIM_W | New stall limit |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | AW | Register address of the source |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |
| done_o | output | 1 | One-cycle end-of-pass strobe |
| done_cnt_o | output | $clog2(WORDS+1) | Words gathered in the pass |
| words_o | output | WORDS*DW | Buffer contents, slot 0 in the low bits |
| underrun_o | output | UND_W | Total empty polls since reset |
| stalled_o | output | 1 | Source shut down after a repeated stall |

## Verification
The bench plays the source. It acknowledges each request half a cycle after the request appears, so every access completes one clock after `bus_req_o` rises. The result of that access is used by the controller on the following edge. A behavioural model walks the same scripted count values, predicts each access with its address, direction and data, and compares them at the cycle in which the bench acknowledges. The pass results are compared in the negedge half-cycle in which `done_o` is high. Launch timing is measured in clock edges: FIRST_DELAY+2 edges from reset release, and INTERVAL+3 edges from the done cycle, to the first count poll of the pass.

// File: rtl/rng_harvest_pkg.sv
package rng_harvest_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_READ,
    ST_RST_OFF,
    ST_RST_MASK,
    ST_RST_WARM,
    ST_RST_ON,
    ST_HALT_OFF,
    ST_DONE,
    ST_DEAD
  } pass_state_e;

endpackage

// File: rtl/rng_launch_timer.sv
module rng_launch_timer #(
  parameter int unsigned FIRST_DELAY = 40,
  parameter int unsigned INTERVAL    = 60,
  parameter int unsigned TW          = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic take_i,
  output logic launch_o
);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= TW'(FIRST_DELAY);
      run_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= TW'(INTERVAL);
      run_q <= 1'b1;
    end else begin
      if (run_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (take_i) run_q <= 1'b0;
    end
  end

  assign launch_o = run_q && (cnt_q == '0);

  // R2
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !launch_o);

  // R2
  take_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !restart_i |=> !launch_o);

endmodule

// File: rtl/rng_bus_master.sv
module rng_bus_master #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (bus_req_o && bus_ack_i) begin
        bus_req_o   <= 1'b0;
        rsp_valid_o <= 1'b1;
        rsp_data_o  <= bus_rdata_i;
      end else if (!bus_req_o && cmd_valid_i) begin
        bus_req_o   <= 1'b1;
        bus_we_o    <= cmd_we_i;
        bus_addr_o  <= cmd_addr_i;
        bus_wdata_o <= cmd_wdata_i;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));

  // R10
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o && rsp_valid_o);

  // R10
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cmd_valid_i);

endmodule

// File: rtl/rng_word_buf.sv
module rng_word_buf #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 4,
  parameter int unsigned SW    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [SW-1:0]       wr_idx_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [WORDS*DW-1:0] words_o
);

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (wr_en_i && wr_idx_i == SW'(g))     slot_q <= wr_data_i;
    end
    assign words_o[g*DW +: DW] = slot_q;
  end

endmodule

// File: rtl/rng_pass_fsm.sv
module rng_pass_fsm
  import rng_harvest_pkg::*;
#(
  parameter int unsigned  AW          = 8,
  parameter int unsigned  DW          = 32,
  parameter int unsigned  WORDS       = 4,
  parameter int unsigned  IW          = 3,
  parameter int unsigned  SW          = 2,
  parameter int unsigned  CNT_LSB     = 24,
  parameter int unsigned  CNT_W       = 8,
  parameter int unsigned  LIM_W       = 8,
  parameter int unsigned  LIM_DEFAULT = 10,
  parameter int unsigned  UND_W       = 16,
  parameter logic [AW-1:0] CTRL_ADDR  = 8'h00,
  parameter logic [AW-1:0] CNT_ADDR   = 8'h04,
  parameter logic [AW-1:0] DATA_ADDR  = 8'h08,
  parameter logic [AW-1:0] MASK_ADDR  = 8'h0C,
  parameter logic [DW-1:0] WARMUP     = 32'h0004_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [LIM_W-1:0] lim_wd_i,
  input  logic             launch_i,
  output logic             take_o,
  output logic             restart_o,
  output logic             cmd_valid_o,
  output logic             cmd_we_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic [DW-1:0]    cmd_wdata_o,
  input  logic             rsp_valid_i,
  input  logic [DW-1:0]    rsp_data_i,
  output logic             buf_we_o,
  output logic [SW-1:0]    buf_idx_o,
  output logic             done_o,
  output logic [IW-1:0]    done_cnt_o,
  output logic [UND_W-1:0] underrun_o,
  output logic             stalled_o
);

  pass_state_e      state_q;
  logic             pend_q, in_pass_q, stall_seen_q, stalled_q;
  logic [IW-1:0]    rem_q, wptr_q, burst_q;
  logic [LIM_W-1:0] empty_q, lim_q, lim_eff;
  logic [LIM_W:0]   empty_nxt;
  logic [UND_W-1:0] under_q;
  logic [CNT_W-1:0] avail, rem_ext;
  logic [IW-1:0]    burst_nxt;
  logic             access;

  assign avail     = rsp_data_i[CNT_LSB +: CNT_W];
  assign rem_ext   = CNT_W'(rem_q);
  assign burst_nxt = (avail > rem_ext) ? rem_q : avail[IW-1:0];
  assign lim_eff   = (lim_q == '0) ? LIM_W'(1) : lim_q;
  assign empty_nxt = {1'b0, empty_q} + 1'b1;

  always_comb begin
    access      = 1'b1;
    cmd_we_o    = 1'b0;
    cmd_addr_o  = CNT_ADDR;
    cmd_wdata_o = '0;
    unique case (state_q)
      ST_POLL:     cmd_addr_o = CNT_ADDR;
      ST_READ:     cmd_addr_o = DATA_ADDR;
      ST_RST_OFF,
      ST_HALT_OFF: begin cmd_we_o = 1'b1; cmd_addr_o = CTRL_ADDR; end
      ST_RST_MASK: begin cmd_we_o = 1'b1; cmd_addr_o = MASK_ADDR; cmd_wdata_o = DW'(1); end
      ST_RST_WARM: begin cmd_we_o = 1'b1; cmd_addr_o = CNT_ADDR;  cmd_wdata_o = WARMUP; end
      ST_RST_ON:   begin cmd_we_o = 1'b1; cmd_addr_o = CTRL_ADDR; cmd_wdata_o = DW'(1); end
      default:     access = 1'b0;
    endcase
  end

  assign cmd_valid_o = access && !pend_q;
  assign take_o      = (state_q == ST_IDLE) && launch_i;
  assign done_o      = (state_q == ST_DONE);
  assign restart_o   = done_o && !stalled_q;
  assign done_cnt_o  = wptr_q;
  assign buf_we_o    = (state_q == ST_READ) && rsp_valid_i;
  assign buf_idx_o   = wptr_q[SW-1:0];
  assign underrun_o  = under_q;
  assign stalled_o   = stalled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= LIM_W'(LIM_DEFAULT);
    end else if (lim_we_i) begin
      lim_q <= lim_wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RST_MASK;
      pend_q       <= 1'b0;
      in_pass_q    <= 1'b0;
      stall_seen_q <= 1'b0;
      stalled_q    <= 1'b0;
      rem_q        <= '0;
      wptr_q       <= '0;
      burst_q      <= '0;
      empty_q      <= '0;
      under_q      <= '0;
    end else begin
      if (rsp_valid_i)      pend_q <= 1'b0;
      else if (cmd_valid_o) pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          in_pass_q    <= 1'b1;
          rem_q        <= IW'(WORDS);
          wptr_q       <= '0;
          empty_q      <= '0;
          stall_seen_q <= 1'b0;
          state_q      <= ST_POLL;
        end
        ST_POLL: if (rsp_valid_i) begin
          if (avail == '0) begin
            under_q <= under_q + 1'b1;
            if (empty_nxt >= {1'b0, lim_eff}) begin
              empty_q <= '0;
              if (stall_seen_q) begin
                state_q <= ST_HALT_OFF;
              end else begin
                stall_seen_q <= 1'b1;
                state_q      <= ST_RST_OFF;
              end
            end else begin
              empty_q <= empty_nxt[LIM_W-1:0];
            end
          end else begin
            burst_q <= burst_nxt;
            state_q <= ST_READ;
          end
        end
        ST_READ: if (rsp_valid_i) begin
          wptr_q  <= wptr_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          burst_q <= burst_q - 1'b1;
          if (burst_q == IW'(1)) state_q <= (rem_q == IW'(1)) ? ST_DONE : ST_POLL;
        end
        ST_RST_OFF:  if (rsp_valid_i) state_q <= ST_RST_MASK;
        ST_RST_MASK: if (rsp_valid_i) state_q <= ST_RST_WARM;
        ST_RST_WARM: if (rsp_valid_i) state_q <= ST_RST_ON;
        ST_RST_ON:   if (rsp_valid_i) state_q <= in_pass_q ? ST_POLL : ST_IDLE;
        ST_HALT_OFF: if (rsp_valid_i) begin
          stalled_q <= 1'b1;
          state_q   <= ST_DONE;
        end
        ST_DONE: begin
          in_pass_q <= 1'b0;
          state_q   <= stalled_q ? ST_DEAD : ST_IDLE;
        end
        default: state_q <= ST_DEAD;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> done_cnt_o <= IW'(WORDS));

  // R4
  pass_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL || state_q == ST_READ) && in_pass_q |->
      ({1'b0, rem_q} + {1'b0, wptr_q}) == (IW+1)'(WORDS));

  // R5
  underrun_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (under_q == $past(under_q)) || (under_q == $past(under_q) + 1'b1));

  // R7
  stalled_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_q |=> stalled_q);

  // R7
  stalled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_q |-> !cmd_valid_o && !restart_o);

endmodule

// File: rtl/rng_harvest_ctrl.sv
module rng_harvest_ctrl #(
  parameter int unsigned   AW          = 8,
  parameter int unsigned   DW          = 32,
  parameter int unsigned   WORDS       = 4,
  parameter int unsigned   CNT_LSB     = 24,
  parameter int unsigned   CNT_W       = 8,
  parameter int unsigned   LIM_W       = 8,
  parameter int unsigned   LIM_DEFAULT = 10,
  parameter int unsigned   UND_W       = 16,
  parameter int unsigned   FIRST_DELAY = 250_000_000,
  parameter int unsigned   INTERVAL    = 1_000_000_000,
  parameter logic [AW-1:0] CTRL_ADDR   = 8'h00,
  parameter logic [AW-1:0] CNT_ADDR    = 8'h04,
  parameter logic [AW-1:0] DATA_ADDR   = 8'h08,
  parameter logic [AW-1:0] MASK_ADDR   = 8'h0C,
  parameter logic [DW-1:0] WARMUP      = 32'h0004_0000,
  localparam int unsigned  IW          = $clog2(WORDS + 1),
  localparam int unsigned  SW          = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned  TW          = $clog2(((FIRST_DELAY > INTERVAL) ? FIRST_DELAY : INTERVAL) + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lim_we_i,
  input  logic [LIM_W-1:0]    lim_wd_i,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [AW-1:0]       bus_addr_o,
  output logic [DW-1:0]       bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic [DW-1:0]       bus_rdata_i,
  output logic                done_o,
  output logic [IW-1:0]       done_cnt_o,
  output logic [WORDS*DW-1:0] words_o,
  output logic [UND_W-1:0]    underrun_o,
  output logic                stalled_o
);

  logic          launch, take, restart;
  logic          cmd_valid, cmd_we, rsp_valid, buf_we;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rsp_data;
  logic [SW-1:0] buf_idx;

  rng_launch_timer #(
    .FIRST_DELAY(FIRST_DELAY), .INTERVAL(INTERVAL), .TW(TW)
  ) u_timer (
    .clk_i, .rst_ni,
    .restart_i(restart), .take_i(take), .launch_o(launch)
  );

  rng_bus_master #(.AW(AW), .DW(DW)) u_bus (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_ack_i, .bus_rdata_i,
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  rng_pass_fsm #(
    .AW(AW), .DW(DW), .WORDS(WORDS), .IW(IW), .SW(SW),
    .CNT_LSB(CNT_LSB), .CNT_W(CNT_W), .LIM_W(LIM_W), .LIM_DEFAULT(LIM_DEFAULT),
    .UND_W(UND_W), .CTRL_ADDR(CTRL_ADDR), .CNT_ADDR(CNT_ADDR),
    .DATA_ADDR(DATA_ADDR), .MASK_ADDR(MASK_ADDR), .WARMUP(WARMUP)
  ) u_fsm (
    .clk_i, .rst_ni, .lim_we_i, .lim_wd_i,
    .launch_i(launch), .take_o(take), .restart_o(restart),
    .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .cmd_wdata_o(cmd_wdata), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx),
    .done_o, .done_cnt_o, .underrun_o, .stalled_o
  );

  rng_word_buf #(.DW(DW), .WORDS(WORDS), .SW(SW)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i(buf_we), .wr_idx_i(buf_idx), .wr_data_i(rsp_data), .words_o
  );

endmodule

// File: tb/tb_rng_harvest_ctrl.sv
module tb_rng_harvest_ctrl;

  localparam int FD = 40;
  localparam int IV = 60;
  localparam logic [7:0]  A_CTRL = 8'h00, A_CNT = 8'h04, A_DATA = 8'h08, A_MASK = 8'h0C;
  localparam logic [31:0] WARM   = 32'h0004_0000;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         lim_we = 1'b0;
  logic [7:0]   lim_wd = 8'd0;
  logic         bus_req, bus_we, bus_ack = 1'b0;
  logic [7:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata = 32'd0;
  logic         done, stalled;
  logic [2:0]   done_cnt;
  logic [127:0] words;
  logic [15:0]  underrun;

  always #2 clk = ~clk;

  rng_harvest_ctrl #(.FIRST_DELAY(FD), .INTERVAL(IV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lim_we_i(lim_we), .lim_wd_i(lim_wd),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .done_o(done), .done_cnt_o(done_cnt), .words_o(words),
    .underrun_o(underrun), .stalled_o(stalled)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0, wd = 0, done_cyc = -1;
  bit launch_pend = 1'b0, prev_done = 1'b0;
  logic [31:0] s_data = 32'hA000_0000, m_data = 32'hA000_0000;
  int avail_q[$], mdl_q[$];
  bit exp_we[$];
  logic [7:0] exp_addr[$];
  logic [31:0] exp_wd[$];
  int m_under = 0, m_cnt = 0;
  bit m_stalled = 1'b0;
  logic [31:0] m_words[4];

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_acc(input bit we, input logic [7:0] a, input logic [31:0] d);
    exp_we.push_back(we); exp_addr.push_back(a); exp_wd.push_back(d);
  endtask

  task automatic push_start();
    push_acc(1, A_MASK, 32'd1);
    push_acc(1, A_CNT, WARM);
    push_acc(1, A_CTRL, 32'd1);
  endtask

  // behavioural reference of one pass
  task automatic model_pass(input int lim);
    int rem = 4, emp = 0, leff;
    bit st = 0;
    leff = (lim == 0) ? 1 : lim;
    m_cnt = 0;
    while (rem > 0) begin
      int a;
      push_acc(0, A_CNT, 32'd0);
      a = (mdl_q.size() != 0) ? mdl_q.pop_front() : 0;
      if (a == 0) begin
        m_under++; emp++;
        if (emp >= leff) begin
          emp = 0;
          push_acc(1, A_CTRL, 32'd0);
          if (st) begin m_stalled = 1'b1; break; end
          st = 1'b1;
          push_start();
        end
      end else begin
        int n;
        n = (a < rem) ? a : rem;
        for (int i = 0; i < n; i++) begin
          push_acc(0, A_DATA, 32'd0);
          m_words[m_cnt] = m_data; m_data++; m_cnt++; rem--;
        end
      end
    end
  endtask

  task automatic script(input int v);
    avail_q.push_back(v); mdl_q.push_back(v);
  endtask

  task automatic wait_pass(input string name);
    do @(negedge clk); while (!done);
    check({"R9 done count ", name}, done_cnt, m_cnt);
    for (int i = 0; i < m_cnt; i++)
      check({"R4 buffer word ", name}, words[i*32 +: 32], m_words[i]);
    check({"R5 underrun total ", name}, underrun, m_under);
    check({"R7 stall flag ", name}, stalled, m_stalled);
    check({"R6 all predicted accesses issued ", name}, exp_addr.size(), 0);
  endtask

  task automatic write_lim(input logic [7:0] v);
    @(negedge clk); lim_we = 1'b1; lim_wd = v;
    @(negedge clk); lim_we = 1'b0;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // source model, access comparison, done and launch monitors
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
    end else begin
      if (done && prev_done) check("R9 done longer than one cycle", 1, 0);
      if (done) begin done_cyc = cyc; launch_pend = 1'b1; end
      prev_done = done;
      if (bus_req && !bus_ack) begin
        if (exp_addr.size() == 0) begin
          check("R7 unexpected bus access", bus_addr, 8'hFF);
        end else begin
          bit e_we; logic [7:0] e_a; logic [31:0] e_d;
          e_we = exp_we.pop_front(); e_a = exp_addr.pop_front(); e_d = exp_wd.pop_front();
          check("R1 R6 access direction", bus_we, e_we);
          check("R1 R6 access address", bus_addr, e_a);
          if (e_we) check("R1 R6 write data", bus_wdata, e_d);
        end
        if (!bus_we && bus_addr == A_CNT && launch_pend) begin
          launch_pend = 1'b0;
          if (done_cyc < 0) check("R2 first launch delay", cyc, FD + 2);
          else              check("R2 launch interval", cyc - done_cyc, IV + 3);
        end
        if (!bus_we && bus_addr == A_CNT) begin
          int a;
          a = (avail_q.size() != 0) ? avail_q.pop_front() : 0;
          bus_rdata <= {a[7:0], 24'h5A5A5A};  // R3 junk below the count field
        end else if (!bus_we && bus_addr == A_DATA) begin
          bus_rdata <= s_data; s_data <= s_data + 1;
        end else begin
          bus_rdata <= 32'hDEAD_BEEF;
        end
        bus_ack <= 1'b1;
      end else begin
        bus_ack <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d", wd, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset request low", bus_req, 0);
    check("R9 reset done low", done, 0);
    check("R5 reset underrun", underrun, 0);
    check("R7 reset stall flag", stalled, 0);
    push_start();                                       // R1
    script(4);                                          // R3 R4 full burst
    model_pass(10);
    launch_pend = 1'b1;
    rst_n = 1'b1;
    wait_pass("P1");

    script(1); script(0); script(2); script(5);         // R4 R5 partial bursts
    model_pass(10);
    wait_pass("P2");

    for (int i = 0; i < 9; i++) script(0);              // R8 default limit 10
    script(4);
    model_pass(10);
    wait_pass("P3");

    write_lim(8'd3);                                    // R6 one restart
    script(0); script(0); script(2); script(0); script(3);
    model_pass(3);
    wait_pass("P4");

    write_lim(8'd0);                                    // R8 zero as one, R7 halt
    script(2); script(0); script(0);
    model_pass(0);
    wait_pass("P5");

    begin
      int seen = 0;
      for (int i = 0; i < 3 * IV; i++) begin
        @(negedge clk);
        if (bus_req || done) seen++;
      end
      check("R7 quiet after shutdown", seen, 0);
      check("R7 stall flag held", stalled, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule